// File: doc/BRIEF.md
# In-Cache Reduction Update Unit

This block sits next to a cache data array and applies reduction updates where the data lives, so the core never has to load a value, combine it and store it back. The core sends one reduction store. It carries a 2-bit destination level, a 1-bit operator, the line and word being updated, and a 32-bit operand. If the destination level equals this cache's level, the unit does a two-cycle read-modify-write on the resident word. If the line is not resident, the unit first fills it with the operator's identity value. A reduction store meant for another level is sent downstream one cycle later with every field unchanged, and it leaves the local array alone.

In a private cache, every word that is updated locally is marked as a partial result. A flush command walks the whole array in ascending word-index order. It emits each marked word downstream as a reduction store aimed at the shared level, which combines the partials. When the walk ends, the unit drops every mark and every resident line, so the next reduction epoch starts again from identity values. Scalar reduction variables use one word. Vector reduction variables use several words of a line, and each word is updated independently of the others.

Top module: `red_cache_unit`

## Requirements
- R1: After reset, req_ready is 1, dn_valid is 0, flush_busy is 0 and rd_valid is 0 for every line.
- R2: A request accepted with req_level equal to LEVEL_ID and req_op = 0 replaces the addressed word with old value plus operand, modulo 2^32. The new value is visible on the read port from the cycle after the second clock edge following acceptance.
- R3: A local request with req_op = 1 replaces the word with the low 32 bits of old value times operand.
- R4: A local request to a line that is not resident first fills every word of that line with the operator's identity (0 for add, 1 for multiply). It then applies the update to the addressed word and makes the line resident.
- R5: While a local update is in its read cycle, a local request to the same line and word sees req_ready = 0. It is accepted one cycle later, and the final value reflects both operands.
- R6: A request whose req_level differs from LEVEL_ID is presented on dn_* on the cycle after acceptance, with level, operator, line, word and data unchanged, and the local array is not modified. A local request never raises dn_valid.
- R7: Updates to different words of the same line are independent: each word accumulates only its own operands.
- R8: When LEVEL_ID differs from SHARED_LEVEL, each local update marks its word. Forwarded requests mark nothing.
- R9: A flush_start pulse while idle raises flush_busy for LINES*WORDS cycles, holding req_ready at 0. In ascending order of index line*WORDS+word, the flush emits each marked word on dn_* with dn_level = SHARED_LEVEL, the word's last operator, its line, its word and its value.
- R10: At the end of a flush, all marks and all resident lines are cleared. A following flush emits nothing, and a later local update reallocates from identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Reduction store present |
| req_ready | output | 1 | Store accepted this cycle when high |
| req_level | input | 2 | Cache level that should perform the reduction |
| req_op | input | 1 | Operator: 0 add, 1 multiply |
| req_line | input | LAW | Line address |
| req_word | input | WAW | Word offset within the line |
| req_data | input | DW | Operand |
| flush_start | input | 1 | Pulse to fold marked partials downstream |
| flush_busy | output | 1 | Flush walk in progress |
| rd_line | input | LAW | Read-port line address |
| rd_word | input | WAW | Read-port word offset |
| rd_valid | output | 1 | Addressed line is resident |
| rd_data | output | DW | Addressed word value |
| dn_valid | output | 1 | Downstream reduction store valid |
| dn_level | output | 2 | Downstream target level |
| dn_op | output | 1 | Downstream operator |
| dn_line | output | LAW | Downstream line address |
| dn_word | output | WAW | Downstream word offset |
| dn_data | output | DW | Downstream operand |

## Verification
The bench builds the unit with LEVEL_ID = 1, SHARED_LEVEL = 2, four lines of four words and 32-bit data. With this setup the instance is a private level, so marking and flush emission both happen. Requests tagged for level 2 exercise the forwarding path. The 16-word array keeps a full flush walk short enough that its exact emission order and its final clearing can be checked word by word. The operands include an addition that wraps past 2^32 and a multiplication whose product overflows, so both truncation rules are exercised.

// File: rtl/red_cache_unit.sv
module red_cache_unit #(
  parameter logic [1:0] LEVEL_ID     = 2'd1,
  parameter logic [1:0] SHARED_LEVEL = 2'd2,
  parameter int         LINES        = 4,
  parameter int         WORDS        = 4,
  parameter int         DW           = 32,
  localparam int        LAW          = $clog2(LINES),
  localparam int        WAW          = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_level,
  input  logic           req_op,
  input  logic [LAW-1:0] req_line,
  input  logic [WAW-1:0] req_word,
  input  logic [DW-1:0]  req_data,
  input  logic           flush_start,
  output logic           flush_busy,
  input  logic [LAW-1:0] rd_line,
  input  logic [WAW-1:0] rd_word,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           dn_valid,
  output logic [1:0]     dn_level,
  output logic           dn_op,
  output logic [LAW-1:0] dn_line,
  output logic [WAW-1:0] dn_word,
  output logic [DW-1:0]  dn_data
);
  localparam int  TOTAL   = LINES * WORDS;
  localparam int  IW      = LAW + WAW;
  localparam bit  PRIVATE = (LEVEL_ID != SHARED_LEVEL);

  logic [DW-1:0]    mem [TOTAL];
  logic [LINES-1:0] lvalid;
  logic [TOTAL-1:0] mark, mop;

  logic             s1_v, s1_op;
  logic [LAW-1:0]   s1_line;
  logic [WAW-1:0]   s1_word;
  logic [DW-1:0]    s1_data;
  logic [IW-1:0]    fl_idx;

  wire [IW-1:0] s1_idx    = {s1_line, s1_word};
  wire          s1_hit    = lvalid[s1_line];
  wire [DW-1:0] ident     = s1_op ? DW'(1) : '0;
  wire [DW-1:0] old_val   = s1_hit ? mem[s1_idx] : ident;
  wire [DW-1:0] result    = s1_op ? old_val * s1_data : old_val + s1_data;
  wire          local_req = (req_level == LEVEL_ID);
  wire          hazard    = s1_v && local_req && ({req_line, req_word} == s1_idx);
  wire          fl_last   = (fl_idx == IW'(TOTAL - 1));

  assign req_ready  = !flush_busy && !flush_start && !hazard;
  wire   acc        = req_valid && req_ready;
  assign rd_valid   = lvalid[rd_line];
  assign rd_data    = mem[{rd_line, rd_word}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_op   <= 1'b0;
      s1_line <= '0;
      s1_word <= '0;
      s1_data <= '0;
    end else begin
      s1_v <= acc && local_req;
      if (acc && local_req) begin
        s1_op   <= req_op;
        s1_line <= req_line;
        s1_word <= req_word;
        s1_data <= req_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (s1_v && (!s1_hit || WAW'(w) == s1_word))
        mem[{s1_line, WAW'(w)}] <= (WAW'(w) == s1_word) ? result : ident;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvalid <= '0;
      mark   <= '0;
      mop    <= '0;
    end else if (flush_busy) begin
      if (fl_last) begin
        lvalid <= '0;
        mark   <= '0;
      end else begin
        mark[fl_idx] <= 1'b0;
      end
    end else if (s1_v) begin
      lvalid[s1_line] <= 1'b1;
      mop[s1_idx]     <= s1_op;
      if (PRIVATE) mark[s1_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_busy <= 1'b0;
      fl_idx     <= '0;
    end else if (!flush_busy && flush_start) begin
      flush_busy <= 1'b1;
      fl_idx     <= '0;
    end else if (flush_busy) begin
      if (fl_last) flush_busy <= 1'b0;
      else         fl_idx     <= fl_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_level <= '0;
      dn_op    <= 1'b0;
      dn_line  <= '0;
      dn_word  <= '0;
      dn_data  <= '0;
    end else begin
      dn_valid <= 1'b0;
      if (flush_busy && mark[fl_idx]) begin
        dn_valid <= 1'b1;
        dn_level <= SHARED_LEVEL;
        dn_op    <= mop[fl_idx];
        dn_line  <= fl_idx[IW-1:WAW];
        dn_word  <= fl_idx[WAW-1:0];
        dn_data  <= mem[fl_idx];
      end else if (acc && !local_req) begin
        dn_valid <= 1'b1;
        dn_level <= req_level;
        dn_op    <= req_op;
        dn_line  <= req_line;
        dn_word  <= req_word;
        dn_data  <= req_data;
      end
    end
  end

  // R6
  fwd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_level != LEVEL_ID) |=>
      (dn_valid && dn_level == $past(req_level) && dn_op == $past(req_op) &&
       dn_data == $past(req_data) && dn_word == $past(req_word)));

  // R6
  local_no_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_level == LEVEL_ID) |=> !dn_valid);

  // R4
  alloc_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> lvalid[$past(s1_line)]);

  // R9
  flush_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && $past(flush_busy)) |-> dn_level == SHARED_LEVEL);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> (mark == '0 && lvalid == '0));

  // R5
  same_word_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && local_req && s1_v) |-> ({req_line, req_word} != s1_idx));
endmodule

// File: tb/test_red_cache_unit.sv
`timescale 1ns/1ps
module test_red_cache_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, flush_start = 1'b0;
  logic [1:0] req_level = 2'd1;
  logic [1:0] req_line = '0, rd_line = '0;
  logic [1:0] req_word = '0, rd_word = '0;
  logic [31:0] req_data = '0;
  logic req_ready, flush_busy, rd_valid, dn_valid, dn_op;
  logic [31:0] rd_data, dn_data;
  logic [1:0] dn_level, dn_line, dn_word;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  red_cache_unit i_red_cache_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_level(req_level), .req_op(req_op), .req_line(req_line), .req_word(req_word),
    .req_data(req_data), .flush_start(flush_start), .flush_busy(flush_busy),
    .rd_line(rd_line), .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data),
    .dn_valid(dn_valid), .dn_level(dn_level), .dn_op(dn_op), .dn_line(dn_line),
    .dn_word(dn_word), .dn_data(dn_data));

  // {op, line, word, operand, expected word value}, all at local level 1
  localparam logic [68:0] VEC [9] = '{
    {1'b0, 2'd0, 2'd0, 32'd5,          32'd5},
    {1'b0, 2'd0, 2'd0, 32'd7,          32'd12},
    {1'b1, 2'd1, 2'd2, 32'd6,          32'd6},
    {1'b1, 2'd1, 2'd2, 32'd3,          32'd18},
    {1'b0, 2'd0, 2'd1, 32'd100,        32'd100},
    {1'b0, 2'd2, 2'd3, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b0, 2'd2, 2'd3, 32'd2,          32'd1},
    {1'b1, 2'd3, 2'd0, 32'd70000,      32'd70000},
    {1'b1, 2'd3, 2'd0, 32'd70000,      32'h2410_1100}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] lvl, input logic op, input logic [1:0] ln,
                      input logic [1:0] wd, input logic [31:0] d);
    req_level = lvl; req_op = op; req_line = ln; req_word = wd; req_data = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek(input logic [1:0] ln, input logic [1:0] wd);
    rd_line = ln; rd_word = wd;
    #0.5;
  endtask

  logic [31:0] got_data [16];
  logic [3:0]  got_idx  [16];
  logic [1:0]  got_lvl  [16];
  logic        got_op   [16];
  int          ngot;

  task automatic run_flush();
    ngot = 0;
    flush_start = 1'b1;
    @(negedge clk);
    flush_start = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low in flush", 32'(req_ready), 32'd0);
    chk(flush_busy == 1'b1, "R9 busy", 32'(flush_busy), 32'd1);
    for (int c = 0; c < 24; c++) begin
      if (dn_valid && ngot < 16) begin
        got_data[ngot] = dn_data;
        got_idx[ngot]  = {dn_line, dn_word};
        got_lvl[ngot]  = dn_level;
        got_op[ngot]   = dn_op;
        ngot++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd0, 2'd0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(dn_valid == 1'b0, "R1 dn_valid", 32'(dn_valid), 32'd0);
    chk(flush_busy == 1'b0, "R1 busy", 32'(flush_busy), 32'd0);
    for (int l = 0; l < 4; l++) begin
      peek(2'(l), 2'd0);
      chk(rd_valid == 1'b0, "R1 line not resident", 32'(rd_valid), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R7 table walk
    for (int i = 0; i < 9; i++) begin
      send(2'd1, VEC[i][68], VEC[i][67:66], VEC[i][65:64], VEC[i][63:32]);
      chk(dn_valid == 1'b0, "R6 local never forwards", 32'(dn_valid), 32'd0);
      @(negedge clk);
      peek(VEC[i][67:66], VEC[i][65:64]);
      chk(rd_valid && rd_data == VEC[i][31:0], VEC[i][68] ? "R3 multiply update" : "R2 add update",
          rd_data, VEC[i][31:0]);
    end

    // R4 identity fill of untouched words
    peek(2'd1, 2'd0);
    chk(rd_data == 32'd1, "R4 multiply identity fill", rd_data, 32'd1);
    peek(2'd0, 2'd3);
    chk(rd_data == 32'd0, "R4 add identity fill", rd_data, 32'd0);
    peek(2'd0, 2'd1);
    chk(rd_data == 32'd100, "R7 neighbour word independent", rd_data, 32'd100);

    // R6 forwarding to another level
    send(2'd2, 1'b1, 2'd0, 2'd0, 32'd99);
    chk(dn_valid && dn_level == 2'd2 && dn_op == 1'b1 && dn_line == 2'd0 && dn_word == 2'd0 && dn_data == 32'd99,
        "R6 forwarded fields", dn_data, 32'd99);
    @(negedge clk);
    chk(dn_valid == 1'b0, "R6 single forward pulse", 32'(dn_valid), 32'd0);
    peek(2'd0, 2'd0);
    chk(rd_data == 32'd12, "R6 local untouched", rd_data, 32'd12);

    // R5 same-word back-to-back
    req_level = 2'd1; req_op = 1'b0; req_line = 2'd0; req_word = 2'd2; req_data = 32'd3;
    req_valid = 1'b1;
    @(negedge clk);
    req_data = 32'd4;
    chk(req_ready == 1'b0, "R5 stall same word", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 accept after write", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    peek(2'd0, 2'd2);
    chk(rd_data == 32'd7, "R5 both operands applied", rd_data, 32'd7);

    // R8 R9 flush of marked partials
    run_flush();
    chk(ngot == 6, "R8 marked word count", 32'(ngot), 32'd6);
    if (ngot == 6) begin
      chk(got_idx[0] == 4'd0  && got_data[0] == 32'd12,  "R9 emit l0w0", got_data[0], 32'd12);
      chk(got_idx[1] == 4'd1  && got_data[1] == 32'd100, "R9 emit l0w1", got_data[1], 32'd100);
      chk(got_idx[2] == 4'd2  && got_data[2] == 32'd7,   "R9 emit l0w2", got_data[2], 32'd7);
      chk(got_idx[3] == 4'd6  && got_data[3] == 32'd18 && got_op[3], "R9 emit l1w2", got_data[3], 32'd18);
      chk(got_idx[4] == 4'd11 && got_data[4] == 32'd1 && !got_op[4], "R9 emit l2w3", got_data[4], 32'd1);
      chk(got_idx[5] == 4'd12 && got_data[5] == 32'h2410_1100 && got_op[5], "R9 emit l3w0",
          got_data[5], 32'h2410_1100);
      for (int k = 0; k < 6; k++)
        chk(got_lvl[k] == 2'd2, "R9 shared level tag", 32'(got_lvl[k]), 32'd2);
    end
    chk(flush_busy == 1'b0, "R9 busy ends", 32'(flush_busy), 32'd0);
    peek(2'd0, 2'd0);
    chk(rd_valid == 1'b0, "R10 lines dropped", 32'(rd_valid), 32'd0);

    // R10 second flush is empty, reallocation from identity
    run_flush();
    chk(ngot == 0, "R10 marks cleared", 32'(ngot), 32'd0);
    send(2'd1, 1'b0, 2'd0, 2'd0, 32'd5);
    @(negedge clk);
    peek(2'd0, 2'd0);
    chk(rd_valid && rd_data == 32'd5, "R10 reallocated from identity", rd_data, 32'd5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule